// File: doc/BRIEF.md
# Flash Command Sequence Controller

This block sits between a simple synchronous byte bus and a small on-chip array that models the cells of a byte-wide flash memory. Reads normally return array contents. Writes are decoded as command cycles: an unlock handshake at two fixed addresses is followed by either a byte-program command or a sector-erase command. Once the final cycle of a command arrives, the block runs the operation for a fixed number of clock cycles.

While an operation runs, every read returns a status byte whose bit 6 flips on each read. Software therefore polls the target address until two reads in a row agree. Command decoding is live only while a control register field holds the enabling code. The array keeps one byte per cell offset within each 4 KB sector, and the erase and program times are scaled down to parameterised cycle counts.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset, no operation is busy, decoding is disabled, `bus_rdata` is 0x00 and every array byte reads 0xFF.
- R2: A control write sets the enable when `ctl_wdata[7:4]` is 4'b0011 and clears it when that field is 4'b1100. Any other field value leaves the enable as it was. While the enable is clear, bus writes never start an operation.
- R3: The write sequence 0xAA to 0xF555, 0x55 to 0xFAAA, 0xA0 to 0xF555, then data D to address X programs cell X. The cell's new value is its old value AND D.
- R4: The write sequence 0xAA@0xF555, 0x55@0xFAAA, 0x80@0xF555, 0xAA@0xF555, 0x55@0xFAAA, then 0x30 to any address sets every byte of the sector chosen by address bits [15:12] to 0xFF. Other sectors are left unchanged.
- R5: A write that does not match the next expected address and data returns decoding to idle. It changes no array byte, so a following final-cycle write has no effect.
- R6: While busy, each read returns a status byte with bits 7 and 5..0 at zero and bit 6 inverted from the previous status read, whatever the address.
- R7: A program stays busy for PROG_CYC cycles and an erase for ERASE_CYC cycles after the clock edge that takes the final write. A read sampled at the last busy edge returns status, and the read on the next edge returns the new data.
- R8: Writes accepted while busy are ignored: a complete command sequence sent during an operation changes nothing.
- R9: `bus_rdata` is registered. It takes the read result on the edge that samples `bus_re` and holds its value while `bus_re` is low.
- R10: Within a sector, only address bits [3:0] select a cell, so addresses that differ only in bits [11:4] reach the same byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 16 | Byte address for reads and writes |
| bus_wdata | input | 8 | Write data / command byte |
| bus_we | input | 1 | Bus write strobe |
| bus_re | input | 1 | Bus read strobe |
| bus_rdata | output | 8 | Registered read data or busy status |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register data, enable field in bits 7:4 |

## Verification
A read result shows on `bus_rdata` one cycle after the edge that samples `bus_re`. The bench drives every strobe for exactly one cycle from a falling edge and reads `bus_rdata` on the next falling edge. Program and erase results become visible PROG_CYC or ERASE_CYC edges after the edge that takes the final command write. The bench waits exactly one cycle short of that count and checks that the read still returns status, then checks that the next read returns the new data. Random traffic instead polls until two reads match and then compares the result with a bench-side array model.

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl #(
  parameter int AW = 16,
  parameter int SECT_AW = 12,
  parameter int CELL_AW = 4,
  parameter int PROG_CYC = 20,
  parameter int ERASE_CYC = 60,
  parameter logic [AW-1:0] UNLOCK_A = 16'hF555,
  parameter logic [AW-1:0] UNLOCK_B = 16'hFAAA
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic [7:0]    bus_wdata,
  input  logic          bus_we,
  input  logic          bus_re,
  output logic [7:0]    bus_rdata,
  input  logic          ctl_we,
  input  logic [7:0]    ctl_wdata
);
  localparam int IDX_AW = AW - SECT_AW + CELL_AW;
  localparam int DEPTH = 1 << IDX_AW;
  localparam int CELLS = 1 << CELL_AW;
  localparam int MAXC = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
  localparam int CW = $clog2(MAXC) + 1;

  typedef enum logic [2:0] {S_IDLE, S_U1, S_U2, S_E1, S_E2, S_E3, S_PG} seq_t;

  seq_t seq;
  logic en, busy, is_erase, tog;
  logic [CW-1:0] cnt;
  logic [IDX_AW-1:0] tidx;
  logic [7:0] tdata;
  logic [7:0] mem [DEPTH];

  wire hit_a = bus_addr == UNLOCK_A;
  wire hit_b = bus_addr == UNLOCK_B;
  wire [IDX_AW-1:0] aidx = {bus_addr[AW-1:SECT_AW], bus_addr[CELL_AW-1:0]};
  wire cmd = bus_we && en && !busy;
  wire start_prog = cmd && seq == S_PG;
  wire start_erase = cmd && seq == S_E3 && bus_wdata == 8'h30;
  wire unused_ok = &{1'b0, bus_addr[SECT_AW-1:CELL_AW], ctl_wdata[3:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) en <= 1'b0;
    else if (ctl_we) begin
      if (ctl_wdata[7:4] == 4'b0011) en <= 1'b1;
      else if (ctl_wdata[7:4] == 4'b1100) en <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !en || busy) seq <= S_IDLE;
    else if (bus_we) begin
      case (seq)
        S_IDLE: seq <= (hit_a && bus_wdata == 8'hAA) ? S_U1 : S_IDLE;
        S_U1:   seq <= (hit_b && bus_wdata == 8'h55) ? S_U2 : S_IDLE;
        S_U2:   seq <= (hit_a && bus_wdata == 8'h80) ? S_E1 :
                       (hit_a && bus_wdata == 8'hA0) ? S_PG : S_IDLE;
        S_E1:   seq <= (hit_a && bus_wdata == 8'hAA) ? S_E2 : S_IDLE;
        S_E2:   seq <= (hit_b && bus_wdata == 8'h55) ? S_E3 : S_IDLE;
        default: seq <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      is_erase <= 1'b0;
      cnt <= '0;
      tidx <= '0;
      tdata <= 8'h00;
      for (int i = 0; i < DEPTH; i++) mem[IDX_AW'(i)] <= 8'hFF;
    end else if (busy) begin
      if (cnt == '0) begin
        busy <= 1'b0;
        if (is_erase)
          for (int i = 0; i < CELLS; i++)
            mem[{tidx[IDX_AW-1:CELL_AW], CELL_AW'(i)}] <= 8'hFF;
        else
          mem[tidx] <= mem[tidx] & tdata;
      end else cnt <= cnt - 1'b1;
    end else if (start_prog || start_erase) begin
      busy <= 1'b1;
      is_erase <= start_erase;
      cnt <= start_erase ? CW'(ERASE_CYC - 1) : CW'(PROG_CYC - 1);
      tidx <= aidx;
      tdata <= bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata <= 8'h00;
      tog <= 1'b0;
    end else if (bus_re) begin
      if (busy) begin
        bus_rdata <= {1'b0, tog, 6'b0};
        tog <= ~tog;
      end else bus_rdata <= mem[aidx];
    end
  end
endmodule

module flash_cmd_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_we,
  input logic       bus_re,
  input logic [7:0] bus_rdata,
  input logic       en,
  input logic       busy,
  input logic       cnt_zero
);
  logic fresh, seen, prev6;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fresh <= 1'b0;
      seen <= 1'b0;
      prev6 <= 1'b0;
    end else begin
      fresh <= busy && bus_re;
      if (fresh) begin
        seen <= 1'b1;
        prev6 <= bus_rdata[6];
      end
    end
  end

  p_start_needs_enable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(bus_we && en));
  p_busy_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !cnt_zero |=> busy);
  p_busy_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy && cnt_zero |=> !busy);
  p_status_shape_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy && bus_re |=> (bus_rdata & 8'hBF) == 8'h00);
  p_status_toggle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fresh && seen |-> bus_rdata[6] != prev6);
  p_rdata_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_re |=> $stable(bus_rdata));
endmodule

bind flash_cmd_ctrl flash_cmd_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re),
  .bus_rdata(bus_rdata), .en(en), .busy(busy), .cnt_zero(cnt == '0)
);

// File: tb/flash_cmd_ctrl_tb.sv
module flash_cmd_ctrl_tb_top;
  localparam int PROG_CYC = 20;
  localparam int ERASE_CYC = 60;
  localparam logic [15:0] UA = 16'hF555, UB = 16'hFAAA;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, ctl_wdata = '0;
  logic bus_we = 1'b0, bus_re = 1'b0, ctl_we = 1'b0;
  logic [7:0] bus_rdata;
  int vec = 0, bad = 0;
  logic [7:0] model [256];

  always #10 clk = ~clk;

  flash_cmd_ctrl #(.PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata));

  function automatic int mi(logic [15:0] a);
    return int'({a[15:12], a[3:0]});
  endfunction

  task automatic chk(bit ok, string req, logic [7:0] act, logic [7:0] exp);
    vec++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(logic [15:0] a, logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [15:0] a, output logic [7:0] d);
    bus_addr = a; bus_re = 1'b1;
    @(negedge clk);
    bus_re = 1'b0;
    d = bus_rdata;
  endtask

  task automatic ctl(logic [7:0] v);
    ctl_wdata = v; ctl_we = 1'b1;
    @(negedge clk);
    ctl_we = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic unlock();
    wr(UA, 8'hAA); wr(UB, 8'h55);
  endtask

  task automatic prog(logic [15:0] a, logic [7:0] d);
    unlock(); wr(UA, 8'hA0); wr(a, d);
  endtask

  task automatic erase(logic [15:0] a);
    unlock(); wr(UA, 8'h80); unlock(); wr(a, 8'h30);
  endtask

  task automatic poll(logic [15:0] a, output logic [7:0] d);
    logic [7:0] p, q;
    rd(a, p);
    for (int k = 0; k < 1000; k++) begin
      rd(a, q);
      if (q == p) break;
      p = q;
    end
    d = q;
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vec, bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=00 expected=01");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] r, s;
    void'($urandom(32'h5EED1234));
    for (int i = 0; i < 256; i++) model[i] = 8'hFF;
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);

    chk(bus_rdata == 8'h00, "R1 rdata after reset", bus_rdata, 8'h00);
    rd(16'hE003, r); chk(r == 8'hFF, "R1 erased after reset", r, 8'hFF);

    prog(16'hE003, 8'h00); idle(PROG_CYC + 5);
    rd(16'hE003, r); chk(r == 8'hFF, "R2 disabled ignores program", r, 8'hFF);

    ctl(8'h38); ctl(8'h58);
    prog(16'hE005, 8'h3C); model[mi(16'hE005)] = 8'h3C;
    rd(16'hE005, r); chk((r & 8'hBF) == 8'h00, "R6 status shape", r, r & 8'h40);
    rd(16'h1234, s); chk(s == (r ^ 8'h40), "R6 status toggles", s, r ^ 8'h40);
    prog(16'hE006, 8'h00);
    poll(16'hE005, r); chk(r == 8'h3C, "R3 program", r, 8'h3C);
    rd(16'hE006, r); chk(r == 8'hFF, "R8 write during busy ignored", r, 8'hFF);

    prog(16'hE007, 8'h0F); model[mi(16'hE007)] = 8'h0F;
    idle(PROG_CYC - 1);
    rd(16'hE007, r); chk((r & 8'hBF) == 8'h00, "R7 still busy at last program edge", r, r & 8'h40);
    rd(16'hE007, r); chk(r == 8'h0F, "R7 program done on time", r, 8'h0F);
    prog(16'hE007, 8'hF3); model[mi(16'hE007)] = 8'h03;
    poll(16'hE007, r); chk(r == 8'h03, "R3 program ANDs bits", r, 8'h03);

    prog(16'hD001, 8'h12); model[mi(16'hD001)] = 8'h12;
    poll(16'hD001, r);
    erase(16'hE800);
    for (int i = 0; i < 16; i++) model[mi(16'hE000) + i] = 8'hFF;
    idle(ERASE_CYC - 1);
    rd(16'hE007, r); chk((r & 8'hBF) == 8'h00, "R7 still busy at last erase edge", r, r & 8'h40);
    rd(16'hE007, r); chk(r == 8'hFF, "R7 erase done on time", r, 8'hFF);
    for (int i = 0; i < 16; i++) begin
      rd(16'hE000 + 16'(i), r); chk(r == 8'hFF, "R4 sector erased", r, 8'hFF);
    end
    rd(16'hD001, r); chk(r == 8'h12, "R4 other sector kept", r, 8'h12);

    unlock(); wr(UA, 8'h90); wr(16'hE001, 8'h00);
    wr(UA, 8'hAA); wr(UA, 8'h55); wr(UA, 8'hA0); wr(16'hE001, 8'h00);
    unlock(); wr(UA, 8'h80); unlock(); wr(16'hE000, 8'h31);
    idle(ERASE_CYC + 5);
    rd(16'hE001, r); chk(r == 8'hFF, "R5 mismatch aborts", r, 8'hFF);
    rd(16'hD001, r); chk(r == 8'h12, "R5 bad erase code aborts", r, 8'h12);

    ctl(8'hC8);
    prog(16'hD001, 8'h00); idle(PROG_CYC + 5);
    rd(16'hD001, r); chk(r == 8'h12, "R2 disable code stops decoding", r, 8'h12);
    ctl(8'h38);

    prog(16'hD7F3, 8'h55); model[mi(16'hD003)] = 8'h55;
    poll(16'hD7F3, r);
    rd(16'hD003, r); chk(r == 8'h55, "R10 offset aliasing", r, 8'h55);
    bus_addr = 16'hE005; idle(3);
    chk(bus_rdata == 8'h55, "R9 rdata holds without read", bus_rdata, 8'h55);

    for (int it = 0; it < 60; it++) begin
      logic [15:0] a, b;
      logic [7:0] d;
      a = 16'($urandom); d = 8'($urandom);
      case ($urandom % 3)
        0: begin
          prog(a, d); model[mi(a)] = model[mi(a)] & d;
          poll(a, r); chk(r == model[mi(a)], "R3 random program", r, model[mi(a)]);
        end
        1: begin
          erase(a);
          for (int i = 0; i < 16; i++) model[(mi(a) & 8'hF0) + i] = 8'hFF;
          poll(a, r); chk(r == 8'hFF, "R4 random erase", r, 8'hFF);
        end
        default: begin
          wr(UA, 8'h00);
          wr(a, (d == 8'hAA) ? 8'h00 : d);
          idle(2);
        end
      endcase
      b = 16'($urandom);
      rd(b, r); chk(r == model[mi(b)], "R5 random array compare", r, model[mi(b)]);
    end

    summary();
    $finish;
  end
endmodule